// File: doc/BRIEF.md
# Dual-Function PCI I/O Window Decoder

This block sits behind the target side of a PCI interface on a device that offers two functions: a storage controller and a network controller. Each function has its own small configuration space, reached through its own IDSEL-style select input. Software uses these spaces to program a command register and an I/O base address register (BAR) for each function. From then on, the block compares every host I/O cycle with the two programmed windows. It raises exactly one select strobe for the register bank that the cycle targets, or none at all. The strobe comes with the doubleword index inside that bank and the byte enables of the cycle.

The storage function asks for a 128-byte aligned window but fills only the first 96 bytes of it. The lower 64 bytes hold its core register bank and the next 32 bytes hold its DMA register bank. The top 32 bytes of that window are a hole that no bank claims. The network function asks for a 32-byte aligned window that is fully populated. Configuration reads return data one clock after the request. I/O decode results are also registered, one clock after the cycle is presented.

Top module: `pciio_dual_decoder`

## Requirements
- R1: A configuration cycle with `cfg_sel_stor` high reaches only the storage function's registers. One with `cfg_sel_net` high and `cfg_sel_stor` low reaches only the network function's registers. When both selects are high, only the storage function is written and read.
- R2: The command register sits at doubleword index 1 (byte offset 04h) and the BAR at doubleword index 4 (byte offset 10h). Every other index reads as 0, and writes to it change nothing. Read data appears on `cfg_rdata` in the clock after the request. It is 0 in any clock that follows no read.
- R3: The storage BAR holds writable bits [31:7]. Bit 0 reads 1 and bits [6:1] read 0, so writing 0xFFFFFFFF reads back as 0xFFFFFF81.
- R4: The network BAR holds writable bits [31:5]. Bit 0 reads 1 and bits [4:1] read 0, so writing 0xFFFFFFFF reads back as 0xFFFFFFE1.
- R5: Only bit 0 (I/O space enable) of each command register is implemented. The other bits read 0.
- R6: After reset, both command registers read 0, both BARs read 0x00000001, and all select strobes are low.
- R7: A storage hit at window offsets 0x00–0x3F raises `sel_core` with `io_off` = address bits [5:2]. Offsets 0x40–0x5F raise `sel_dma` with `io_off` = address bits [4:2]. Offsets 0x60–0x7F raise no strobe. Strobes appear in the clock after the cycle is presented.
- R8: When address bits [31:5] match the network BAR, the network window raises `sel_net` with `io_off` = address bits [4:2].
- R9: A function claims no I/O cycle while bit 0 of its command register is 0.
- R10: When the windows overlap, a storage bank claim wins over the network window. The storage hole does not block the network window. At most one strobe is high at any time.
- R11: Configuration writes update only the bytes whose `cfg_be` bit is set. `io_be_out` carries the cycle's byte enables while a strobe is high. `io_off` and `io_be_out` are 0 while no strobe is high.
- R12: No strobe is raised in the clock after a cycle where `io_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration access this clock |
| cfg_sel_stor | input | 1 | Configuration select for the storage function |
| cfg_sel_net | input | 1 | Configuration select for the network function |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_dw_idx | input | 6 | Doubleword index in configuration space |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_rdata | output | 32 | Configuration read data, one clock later |
| io_valid | input | 1 | Host I/O cycle this clock |
| io_addr | input | 32 | Host I/O byte address |
| io_be | input | 4 | Host I/O byte enables |
| sel_core | output | 1 | Storage core bank select |
| sel_dma | output | 1 | Storage DMA bank select |
| sel_net | output | 1 | Network bank select |
| io_off | output | 4 | Doubleword index within the selected bank |
| io_be_out | output | 4 | Byte enables of the selected cycle |

## Verification
The bench targets the storage hole at 0x60–0x7F. A decoder that compared only the 128-byte base would claim those offsets as core or DMA accesses. It also places a network window inside the DMA bank and another inside the hole. This shows whether priority follows actual bank claims: a wrong design either raises two strobes or lets the network window lose in the hole. Partial-byte and all-ones BAR writes expose wrong size masks or a missing bit 0. Accesses with the enable bit cleared catch a decoder that claims cycles with its window switched off.

// File: rtl/pciio_pkg.sv
`timescale 1ns/1ps
package pciio_pkg;
    localparam int DW       = 32;
    localparam int CFG_IDX_W = 6;
    localparam int BE_W     = DW / 8;

    typedef enum logic [1:0] {
        BANK_NONE = 2'd0,
        BANK_CORE = 2'd1,
        BANK_DMA  = 2'd2,
        BANK_NET  = 2'd3
    } bank_e;
endpackage

// File: rtl/cfgfn_regs.sv
`timescale 1ns/1ps
module cfgfn_regs
    import pciio_pkg::*;
#(
    parameter int ALIGN_LG = 7,
    parameter int CMD_IDX  = 1,
    parameter int BAR_IDX  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CFG_IDX_W-1:0] dw_idx,
    input  logic [DW-1:0]        wdata,
    input  logic [BE_W-1:0]      be,
    output logic                 io_en,
    output logic [DW-1:ALIGN_LG] base_hi,
    output logic [DW-1:0]        rd_word
);
    typedef struct packed {
        logic                 io_en;
        logic [DW-1:ALIGN_LG] base;
    } fn_state_t;

    fn_state_t st_d, st_q;
    logic [DW-1:0] img_cur, img_new;

    always_comb begin
        st_d    = st_q;
        img_cur = {st_q.base, {ALIGN_LG{1'b0}}};
        img_new = img_cur;
        for (int b = 0; b < DW; b++) begin
            if (be[b / 8]) img_new[b] = wdata[b];
        end
        if (wr_en && dw_idx == CFG_IDX_W'(CMD_IDX) && be[0]) begin
            st_d.io_en = wdata[0];
        end
        if (wr_en && dw_idx == CFG_IDX_W'(BAR_IDX)) begin
            st_d.base = img_new[DW-1:ALIGN_LG];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_word = '0;
        if (dw_idx == CFG_IDX_W'(CMD_IDX)) rd_word = {{(DW-1){1'b0}}, st_q.io_en};
        else if (dw_idx == CFG_IDX_W'(BAR_IDX))
            rd_word = {st_q.base, {(ALIGN_LG-1){1'b0}}, 1'b1};
    end

    assign io_en   = st_q.io_en;
    assign base_hi = st_q.base;

    // R11: a BAR write with no byte enabled leaves the base untouched
    a_r11_be_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dw_idx == CFG_IDX_W'(BAR_IDX) && be == '0) |=> $stable(base_hi));

    // R2: writes to unimplemented indices change nothing
    a_r2_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dw_idx != CFG_IDX_W'(BAR_IDX) && dw_idx != CFG_IDX_W'(CMD_IDX))
        |=> ($stable(base_hi) && $stable(io_en)));
endmodule

// File: rtl/io_window_match.sv
`timescale 1ns/1ps
module io_window_match
    import pciio_pkg::*;
#(
    parameter int ALIGN_LG = 7
) (
    input  logic                 en,
    input  logic                 valid,
    input  logic [DW-1:ALIGN_LG] addr_hi,
    input  logic [DW-1:ALIGN_LG] base_hi,
    output logic                 hit
);
    always_comb begin
        hit = en && valid && (addr_hi == base_hi);
    end
endmodule

// File: rtl/pciio_dual_decoder.sv
`timescale 1ns/1ps
module pciio_dual_decoder
    import pciio_pkg::*;
#(
    parameter int STOR_ALIGN_LG = 7,
    parameter int NET_ALIGN_LG  = 5,
    parameter int CORE_LG       = 6,
    parameter int DMA_LG        = 5,
    parameter int CMD_IDX       = 1,
    parameter int BAR_IDX       = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic                 cfg_sel_stor,
    input  logic                 cfg_sel_net,
    input  logic                 cfg_write,
    input  logic [5:0]           cfg_dw_idx,
    input  logic [31:0]          cfg_wdata,
    input  logic [3:0]           cfg_be,
    output logic [31:0]          cfg_rdata,
    input  logic                 io_valid,
    input  logic [31:0]          io_addr,
    input  logic [3:0]           io_be,
    output logic                 sel_core,
    output logic                 sel_dma,
    output logic                 sel_net,
    output logic [3:0]           io_off,
    output logic [3:0]           io_be_out
);
    localparam int CORE_BYTES = 1 << CORE_LG;
    localparam int DMA_BYTES  = 1 << DMA_LG;
    localparam int DMA_WORDS  = DMA_BYTES / 4;
    localparam int OFF_W      = CORE_LG - 2;

    typedef struct packed {
        bank_e             bank;
        logic [OFF_W-1:0]  off;
        logic [BE_W-1:0]   be;
        logic [DW-1:0]     rdata;
    } dec_state_t;

    dec_state_t dec_d, dec_q;

    logic                      stor_wr, net_wr;
    logic                      stor_en, net_en;
    logic [DW-1:STOR_ALIGN_LG] stor_base;
    logic [DW-1:NET_ALIGN_LG]  net_base;
    logic [DW-1:0]             stor_rd, net_rd;
    logic                      stor_hit, net_hit;
    logic [STOR_ALIGN_LG-1:0]  s_rel, s_dma_rel;
    logic [NET_ALIGN_LG-1:0]   n_rel;
    logic                      core_claim, dma_claim, net_claim;

    assign stor_wr = cfg_valid && cfg_write && cfg_sel_stor;
    assign net_wr  = cfg_valid && cfg_write && cfg_sel_net && !cfg_sel_stor;

    cfgfn_regs #(.ALIGN_LG(STOR_ALIGN_LG), .CMD_IDX(CMD_IDX), .BAR_IDX(BAR_IDX)) u_stor_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(stor_wr), .dw_idx(cfg_dw_idx),
        .wdata(cfg_wdata), .be(cfg_be), .io_en(stor_en), .base_hi(stor_base),
        .rd_word(stor_rd)
    );

    cfgfn_regs #(.ALIGN_LG(NET_ALIGN_LG), .CMD_IDX(CMD_IDX), .BAR_IDX(BAR_IDX)) u_net_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(net_wr), .dw_idx(cfg_dw_idx),
        .wdata(cfg_wdata), .be(cfg_be), .io_en(net_en), .base_hi(net_base),
        .rd_word(net_rd)
    );

    io_window_match #(.ALIGN_LG(STOR_ALIGN_LG)) u_stor_match (
        .en(stor_en), .valid(io_valid), .addr_hi(io_addr[DW-1:STOR_ALIGN_LG]),
        .base_hi(stor_base), .hit(stor_hit)
    );

    io_window_match #(.ALIGN_LG(NET_ALIGN_LG)) u_net_match (
        .en(net_en), .valid(io_valid), .addr_hi(io_addr[DW-1:NET_ALIGN_LG]),
        .base_hi(net_base), .hit(net_hit)
    );

    always_comb begin
        dec_d      = '0;
        dec_d.bank = BANK_NONE;
        s_rel      = io_addr[STOR_ALIGN_LG-1:0];
        n_rel      = io_addr[NET_ALIGN_LG-1:0];
        s_dma_rel  = s_rel - STOR_ALIGN_LG'(CORE_BYTES);
        core_claim = stor_hit && (s_rel < STOR_ALIGN_LG'(CORE_BYTES));
        dma_claim  = stor_hit && !core_claim
                     && (s_rel < STOR_ALIGN_LG'(CORE_BYTES + DMA_BYTES));
        net_claim  = net_hit && !core_claim && !dma_claim;

        if (core_claim) begin
            dec_d.bank = BANK_CORE;
            dec_d.off  = OFF_W'(s_rel >> 2);
            dec_d.be   = io_be;
        end else if (dma_claim) begin
            dec_d.bank = BANK_DMA;
            dec_d.off  = OFF_W'(s_dma_rel >> 2);
            dec_d.be   = io_be;
        end else if (net_claim) begin
            dec_d.bank = BANK_NET;
            dec_d.off  = OFF_W'(n_rel >> 2);
            dec_d.be   = io_be;
        end

        if (cfg_valid && !cfg_write) begin
            if (cfg_sel_stor)     dec_d.rdata = stor_rd;
            else if (cfg_sel_net) dec_d.rdata = net_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign sel_core  = (dec_q.bank == BANK_CORE);
    assign sel_dma   = (dec_q.bank == BANK_DMA);
    assign sel_net   = (dec_q.bank == BANK_NET);
    assign io_off    = dec_q.off;
    assign io_be_out = dec_q.be;
    assign cfg_rdata = dec_q.rdata;

    // R10: never more than one strobe
    a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_core, sel_dma, sel_net}));

    // R9: storage strobes only follow an enabled storage function
    a_r9_stor_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!stor_en) |=> !(sel_core || sel_dma));

    // R9: network strobe only follows an enabled network function
    a_r9_net_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!net_en) |=> !sel_net);

    // R12: idle bus gives no strobe
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_valid) |=> !(sel_core || sel_dma || sel_net));

    // R7: DMA index stays inside its bank
    a_r7_dma_off: assert property (@(posedge clk) disable iff (!rst_n)
        sel_dma |-> (io_off < OFF_W'(DMA_WORDS)));

    // R11: side outputs quiet without a strobe
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_core || sel_dma || sel_net) |-> (io_off == '0 && io_be_out == '0));
endmodule

// File: tb/pciio_dual_decoder_tb.sv
`timescale 1ns/1ps
module pciio_dual_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_sel_stor = 1'b0, cfg_sel_net = 1'b0, cfg_write = 1'b0;
    logic [5:0]  cfg_dw_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;
    logic        io_valid = 1'b0;
    logic [31:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic        sel_core, sel_dma, sel_net;
    logic [3:0]  io_off, io_be_out;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    logic [31:0] m_sbar = '0, m_nbar = '0;
    logic        m_sen = 1'b0, m_nen = 1'b0;

    always #4 clk = ~clk;

    pciio_dual_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel_stor(cfg_sel_stor),
        .cfg_sel_net(cfg_sel_net), .cfg_write(cfg_write), .cfg_dw_idx(cfg_dw_idx),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .io_valid(io_valid), .io_addr(io_addr), .io_be(io_be),
        .sel_core(sel_core), .sel_dma(sel_dma), .sel_net(sel_net),
        .io_off(io_off), .io_be_out(io_be_out)
    );

    function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] nw,
                                          input logic [3:0] be, input logic [31:0] mask);
        logic [31:0] r = cur;
        for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = nw[k*8 +: 8];
        return r & mask;
    endfunction

    function automatic logic [31:0] exp_rd(input bit s, input bit n, input logic [5:0] idx);
        if (s) begin
            if (idx == 6'd1) return {31'd0, m_sen};
            if (idx == 6'd4) return m_sbar | 32'h1;
            return 32'h0;
        end
        if (n) begin
            if (idx == 6'd1) return {31'd0, m_nen};
            if (idx == 6'd4) return m_nbar | 32'h1;
            return 32'h0;
        end
        return 32'h0;
    endfunction

    // returns {core, dma, net, off[3:0], be[3:0]}
    function automatic logic [10:0] exp_io(input bit v, input logic [31:0] a, input logic [3:0] be);
        logic [6:0] rel = a[6:0];
        bit shit = v && m_sen && (a[31:7] == m_sbar[31:7]);
        bit nhit = v && m_nen && (a[31:5] == m_nbar[31:5]);
        if (shit && rel < 7'h40) return {3'b100, a[5:2], be};
        if (shit && rel < 7'h60) return {3'b010, 1'b0, a[4:2], be};
        if (nhit)                return {3'b001, 1'b0, a[4:2], be};
        return 11'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input bit s, input bit n, input logic [5:0] idx,
                          input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_sel_stor = s; cfg_sel_net = n;
        cfg_dw_idx = idx; cfg_wdata = d; cfg_be = be;
        if (s) begin
            if (idx == 6'd1 && be[0]) m_sen = d[0];
            if (idx == 6'd4) m_sbar = merge(m_sbar, d, be, 32'hFFFF_FF80);
        end else if (n) begin
            if (idx == 6'd1 && be[0]) m_nen = d[0];
            if (idx == 6'd4) m_nbar = merge(m_nbar, d, be, 32'hFFFF_FFE0);
        end
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0; cfg_sel_stor = 0; cfg_sel_net = 0; cfg_be = 0;
    endtask

    task automatic cfg_rd(input bit s, input bit n, input logic [5:0] idx, input string req);
        logic [31:0] e;
        @(negedge clk);
        cfg_valid = 1; cfg_write = 0; cfg_sel_stor = s; cfg_sel_net = n; cfg_dw_idx = idx;
        e = exp_rd(s, n, idx);
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 0; cfg_sel_stor = 0; cfg_sel_net = 0;
        chk(req, cfg_rdata, e);
    endtask

    task automatic io_cyc(input bit v, input logic [31:0] a, input logic [3:0] be, input string req);
        logic [10:0] e;
        @(negedge clk);
        io_valid = v; io_addr = a; io_be = be;
        e = exp_io(v, a, be);
        @(posedge clk);
        @(negedge clk);
        io_valid = 0;
        chk(req, {21'd0, sel_core, sel_dma, sel_net, io_off, io_be_out}, {21'd0, e});
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R6: reset values
        chk("R6 outputs", {29'd0, sel_core, sel_dma, sel_net}, 32'd0);
        cfg_rd(1, 0, 6'd4, "R6 stor BAR");
        cfg_rd(0, 1, 6'd4, "R6 net BAR");
        cfg_rd(1, 0, 6'd1, "R6 stor cmd");
        cfg_rd(0, 1, 6'd1, "R6 net cmd");
        io_cyc(1, 32'h0000_0010, 4'hF, "R9 disabled at reset");

        // R3 / R4: size masks
        cfg_wr(1, 0, 6'd4, 32'hFFFF_FFFF, 4'hF);
        cfg_rd(1, 0, 6'd4, "R3 stor size mask");
        chk("R3 literal", exp_rd(1, 0, 6'd4), 32'hFFFF_FF81);
        cfg_wr(0, 1, 6'd4, 32'hFFFF_FFFF, 4'hF);
        cfg_rd(0, 1, 6'd4, "R4 net size mask");
        chk("R4 literal", exp_rd(0, 1, 6'd4), 32'hFFFF_FFE1);

        // R5: command register width
        cfg_wr(1, 0, 6'd1, 32'hFFFF_FFFF, 4'hF);
        cfg_rd(1, 0, 6'd1, "R5 stor cmd bit0 only");

        // R2: other index ignored
        cfg_wr(1, 0, 6'd2, 32'hDEAD_BEEF, 4'hF);
        cfg_rd(1, 0, 6'd2, "R2 unimplemented reads 0");
        cfg_rd(1, 0, 6'd4, "R2 BAR unchanged");

        // R1: both selects -> storage only
        cfg_wr(1, 1, 6'd4, 32'h0000_1000, 4'hF);
        cfg_rd(1, 0, 6'd4, "R1 stor written");
        cfg_rd(0, 1, 6'd4, "R1 net untouched");
        cfg_rd(1, 1, 6'd4, "R1 both read stor");

        // R11: partial byte write
        cfg_wr(0, 1, 6'd4, 32'h0000_1060, 4'h1);
        cfg_rd(0, 1, 6'd4, "R11 partial byte");
        cfg_wr(0, 1, 6'd4, 32'h0000_1060, 4'hF);
        cfg_wr(0, 1, 6'd1, 32'h1, 4'h1);

        // R7 banks and hole, R10 hole lets net claim
        io_cyc(1, 32'h0000_1000, 4'h3, "R7 core first");
        io_cyc(1, 32'h0000_103C, 4'hF, "R7 core last");
        io_cyc(1, 32'h0000_1040, 4'h8, "R7 dma first");
        io_cyc(1, 32'h0000_105C, 4'hF, "R7 dma last");
        io_cyc(1, 32'h0000_1064, 4'h5, "R10 net in stor hole");
        io_cyc(0, 32'h0000_1004, 4'hF, "R12 idle");
        // R10: net overlaps DMA bank
        cfg_wr(0, 1, 6'd4, 32'h0000_1040, 4'hF);
        io_cyc(1, 32'h0000_1048, 4'hF, "R10 stor wins");
        // R8 network alone
        cfg_wr(0, 1, 6'd4, 32'h0000_2020, 4'hF);
        io_cyc(1, 32'h0000_203C, 4'h2, "R8 net last");
        io_cyc(1, 32'h0000_2040, 4'h2, "R8 net outside");
        // hole with no net -> nothing
        io_cyc(1, 32'h0000_1070, 4'hF, "R7 hole silent");
        // R9: disable storage
        cfg_wr(1, 0, 6'd1, 32'h0, 4'h1);
        io_cyc(1, 32'h0000_1000, 4'hF, "R9 stor disabled");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int pick;
            logic [31:0] a;
            pick = $urandom_range(0, 9);
            if (pick == 0) cfg_wr(1, 0, 6'd4, $urandom & 32'h0000_3FFF, 4'($urandom));
            else if (pick == 1) cfg_wr(0, 1, 6'd4, $urandom & 32'h0000_3FFF, 4'($urandom));
            else if (pick == 2) cfg_wr($urandom_range(0, 1), $urandom_range(0, 1), 6'd1,
                                       $urandom, 4'hF);
            else if (pick == 3) cfg_rd($urandom_range(0, 1), $urandom_range(0, 1),
                                       6'($urandom_range(0, 7)), "R2 random read");
            else begin
                if (pick < 7)      a = m_sbar + 32'($urandom_range(0, 127));
                else if (pick < 9) a = m_nbar + 32'($urandom_range(0, 31));
                else               a = $urandom & 32'h0000_3FFF;
                io_cyc($urandom_range(0, 7) != 0, a, 4'($urandom), "R7 R8 R10 random io");
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule